// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block keeps a 64-bit interrupt status word and a 64-bit interrupt enable word for a storage host adapter, both reached through a 32-bit register port with one-cycle combinational reads and single-cycle writes. Hardware event pulses set individual status bits: one bit for "completions posted" and one for "message posted". Software acknowledges by writing ones to the status halves, and programs the enable word by writing whole halves.

A mode input selects how the interrupt leaves the block. In legacy mode a level line stays high while any enabled status bit is set. In message mode the level line is held low. Instead, every evaluation point (a set event, a status write or an enable write) that finds an enabled status bit sets produces a single-cycle notification pulse. When software acknowledges while the completion path still holds finished work, the block asks that path for another completion pass. An adapter reset input clears the status word and leaves the enable word as it was.

Top module: `irq_status_ctrl`

## Requirements
- R1: A completion event pulse sets status bit 0, and a message event pulse sets status bit 1, from the next clock edge. An event that arrives in the same cycle as a clearing write to the same bit leaves the bit set.
- R2: A write to byte offset 0x00 (status bits 31:0) or 0x04 (status bits 63:32) clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R3: A write to offset 0x08 (enable bits 31:0) or 0x0C (enable bits 63:32) replaces that whole half of the enable word and leaves the other half unchanged.
- R4: With the mode input at 0 (legacy), the level output is 1 exactly when the bitwise AND of status and enable is non-zero, starting with the cycle after the change.
- R5: With the mode input at 1 (message), an evaluation point whose resulting status AND enable is non-zero raises the notification output for exactly one cycle after the edge, and the level output stays 0.
- R6: In message mode, no notification is produced when an evaluation finds status AND enable equal to zero, or when no evaluation point occurs.
- R7: A write to either status offset while the completion-pending input is 1 raises the retry request for one cycle after the edge. Enable writes, and status writes while nothing is pending, do not raise it.
- R8: Reads return the status halves at 0x00 and 0x04, the enable halves at 0x08 and 0x0C, and the command-status input halves at 0x10 and 0x14. Any other offset reads as 0.
- R9: An adapter reset pulse clears the whole status word at the next edge, overrides events in the same cycle, and keeps the enable word.
- R10: After the asynchronous reset, status, enable, level, notification and retry outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adapter_rst | input | 1 | Synchronous clear of the status word |
| msi_mode | input | 1 | 1 selects pulse notification, 0 selects level line |
| cmpl_evt | input | 1 | Completion event pulse |
| msg_evt | input | 1 | Message event pulse |
| cmpl_pending | input | 1 | Completion path still holds finished work |
| cmd_stat | input | 64 | Command status value presented for reads |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| irq_level | output | 1 | Legacy interrupt level |
| msi_pulse | output | 1 | One-cycle message notification |
| retry_req | output | 1 | One-cycle request for another completion pass |

## Verification
Every stimulus is held for one clock cycle. Register state, the level line, the notification pulse and the retry request all become visible right after that edge, so each is due one cycle after the stimulus. The bench drives on a falling edge and checks at the following falling edge. Read data is combinational, so it is sampled a short delay after the address changes, with no edge in between. For one-shot behaviour, the bench checks again one cycle later that the pulse has dropped and that idle cycles produce no new pulse.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int REG_W    = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int CMPL_BIT = 0,
  parameter int MSG_BIT  = 1,
  parameter int STAT_OFS = 'h00,
  parameter int MASK_OFS = 'h08,
  parameter int CMD_OFS  = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adapter_rst,
  input  logic              msi_mode,
  input  logic              cmpl_evt,
  input  logic              msg_evt,
  input  logic              cmpl_pending,
  input  logic [REG_W-1:0]  cmd_stat,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_level,
  output logic              msi_pulse,
  output logic              retry_req
);
  localparam int NW    = REG_W / DATA_W;
  localparam int BYTES = DATA_W / 8;

  logic [REG_W-1:0] status_q, status_n, mask_q, mask_n, clr, set;
  logic stat_wr, mask_wr, eval, raise_n;

  always_comb begin
    clr     = '0;
    mask_n  = mask_q;
    stat_wr = 1'b0;
    mask_wr = 1'b0;
    for (int k = 0; k < NW; k++) begin
      if (wr_en && addr == ADDR_W'(STAT_OFS + k*BYTES)) begin
        clr[k*DATA_W +: DATA_W] = wdata;
        stat_wr = 1'b1;
      end
      if (wr_en && addr == ADDR_W'(MASK_OFS + k*BYTES)) begin
        mask_n[k*DATA_W +: DATA_W] = wdata;
        mask_wr = 1'b1;
      end
    end
    set = '0;
    set[CMPL_BIT] = cmpl_evt;
    set[MSG_BIT]  = msg_evt;
    status_n = adapter_rst ? '0 : ((status_q & ~clr) | set);
  end

  assign raise_n   = |(status_n & mask_n);
  assign eval      = cmpl_evt | msg_evt | stat_wr | mask_wr;
  assign irq_level = ~msi_mode & |(status_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      mask_q    <= '0;
      msi_pulse <= 1'b0;
      retry_req <= 1'b0;
    end else begin
      status_q  <= status_n;
      mask_q    <= mask_n;
      msi_pulse <= msi_mode & eval & raise_n;
      retry_req <= stat_wr & cmpl_pending;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NW; k++) begin
      if (addr == ADDR_W'(STAT_OFS + k*BYTES)) rd_data = status_q[k*DATA_W +: DATA_W];
      if (addr == ADDR_W'(MASK_OFS + k*BYTES)) rd_data = mask_q[k*DATA_W +: DATA_W];
      if (addr == ADDR_W'(CMD_OFS + k*BYTES))  rd_data = cmd_stat[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int REG_W    = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int CMPL_BIT = 0,
  parameter int MASK_OFS = 'h08,
  parameter int STAT_OFS = 'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adapter_rst,
  input logic              msi_mode,
  input logic              cmpl_evt,
  input logic              cmpl_pending,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [REG_W-1:0]  status_q,
  input logic [REG_W-1:0]  mask_q,
  input logic              msi_pulse,
  input logic              retry_req
);
  p_cmpl_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_evt && !adapter_rst) |=> status_q[CMPL_BIT]);

  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(STAT_OFS) && wdata[CMPL_BIT] && !cmpl_evt)
      |=> !status_q[CMPL_BIT]);

  p_mask_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(MASK_OFS)) |=> mask_q[DATA_W-1:0] == $past(wdata));

  p_pulse_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> $past(msi_mode));

  p_pulse_needs_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> (|(status_q & mask_q)));

  p_retry_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> $past(cmpl_pending && wr_en));

  p_areset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adapter_rst |=> status_q == '0);
endmodule

bind irq_status_ctrl irq_status_chk #(
  .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMPL_BIT(CMPL_BIT),
  .MASK_OFS(MASK_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adapter_rst(adapter_rst), .msi_mode(msi_mode),
  .cmpl_evt(cmpl_evt), .cmpl_pending(cmpl_pending), .addr(addr), .wr_en(wr_en),
  .wdata(wdata), .status_q(status_q), .mask_q(mask_q), .msi_pulse(msi_pulse),
  .retry_req(retry_req)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adapter_rst = 1'b0, msi_mode = 1'b0, cmpl_evt = 1'b0, msg_evt = 1'b0;
  logic        cmpl_pending = 1'b0, wr_en = 1'b0;
  logic [63:0] cmd_stat = 64'hA5A5_0000_1234_5678;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0, rd_data;
  logic        irq_level, msi_pulse, retry_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .adapter_rst(adapter_rst), .msi_mode(msi_mode),
    .cmpl_evt(cmpl_evt), .msg_evt(msg_evt), .cmpl_pending(cmpl_pending),
    .cmd_stat(cmd_stat), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_data(rd_data), .irq_level(irq_level), .msi_pulse(msi_pulse),
    .retry_req(retry_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1 d = rd_data;
  endtask

  task automatic evt(logic c, logic m);
    @(negedge clk); cmpl_evt = c; msg_evt = m;
    @(negedge clk); cmpl_evt = 1'b0; msg_evt = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(8'h00, d); chk("R10 status lo", d, 0);
    rd(8'h04, d); chk("R10 status hi", d, 0);
    rd(8'h08, d); chk("R10 mask lo", d, 0);
    rd(8'h0C, d); chk("R10 mask hi", d, 0);
    chk("R10 level", 32'(irq_level), 0);
    chk("R10 pulse", 32'(msi_pulse), 0);
    chk("R10 retry", 32'(retry_req), 0);
    rd(8'h10, d); chk("R8 cmd lo", d, 32'h1234_5678);
    rd(8'h14, d); chk("R8 cmd hi", d, 32'hA5A5_0000);
    rd(8'h18, d); chk("R8 unknown", d, 0);
    rd(8'h03, d); chk("R8 unaligned", d, 0);
  endtask

  task automatic t_legacy();
    logic [31:0] d;
    msi_mode = 1'b0;
    wr(8'h08, 32'h1);
    chk("R4 no status no level", 32'(irq_level), 0);
    chk("R6 legacy no pulse", 32'(msi_pulse), 0);
    evt(1'b1, 1'b0);
    chk("R4 level after cmpl", 32'(irq_level), 1);
    rd(8'h00, d); chk("R1 cmpl bit", d, 32'h1);
    evt(1'b0, 1'b1);
    rd(8'h00, d); chk("R1 msg bit", d, 32'h3);
    chk("R4 level kept", 32'(irq_level), 1);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R2 zero write keeps", d, 32'h3);
    wr(8'h00, 32'h1);
    rd(8'h00, d); chk("R2 clear bit0", d, 32'h2);
    chk("R4 level drops", 32'(irq_level), 0);
    wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'h0C, d); chk("R3 mask hi", d, 32'hDEAD_BEEF);
    rd(8'h08, d); chk("R3 mask lo kept", d, 32'h1);
    wr(8'h08, 32'h2);
    chk("R4 level via msg bit", 32'(irq_level), 1);
    rd(8'h0C, d); chk("R3 hi kept", d, 32'hDEAD_BEEF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R2 hi write leaves lo", d, 32'h2);
    wr(8'h00, 32'h2);
    rd(8'h00, d); chk("R2 clear bit1", d, 32'h0);
    chk("R4 level zero", 32'(irq_level), 0);
  endtask

  task automatic t_message();
    msi_mode = 1'b1;
    wr(8'h08, 32'h1);
    chk("R6 eval no raise", 32'(msi_pulse), 0);
    evt(1'b1, 1'b0);
    chk("R5 pulse on cmpl", 32'(msi_pulse), 1);
    chk("R5 level held low", 32'(irq_level), 0);
    @(negedge clk);
    chk("R5 one cycle", 32'(msi_pulse), 0);
    repeat (3) @(negedge clk);
    chk("R6 idle no pulse", 32'(msi_pulse), 0);
    evt(1'b0, 1'b1);
    chk("R5 re-eval pulses", 32'(msi_pulse), 1);
    wr(8'h00, 32'h1);
    chk("R6 clear leaves none", 32'(msi_pulse), 0);
    wr(8'h08, 32'h2);
    chk("R5 mask write pulses", 32'(msi_pulse), 1);
    chk("R5 level low", 32'(irq_level), 0);
    wr(8'h00, 32'h2);
    chk("R6 cleared no pulse", 32'(msi_pulse), 0);
  endtask

  task automatic t_retry();
    cmpl_pending = 1'b1;
    wr(8'h00, 32'h0);
    chk("R7 retry on ack", 32'(retry_req), 1);
    @(negedge clk);
    chk("R7 retry one cycle", 32'(retry_req), 0);
    wr(8'h0C, 32'h0);
    chk("R7 mask write no retry", 32'(retry_req), 0);
    cmpl_pending = 1'b0;
    wr(8'h04, 32'h0);
    chk("R7 nothing pending", 32'(retry_req), 0);
  endtask

  task automatic t_collide_and_areset();
    logic [31:0] d;
    msi_mode = 1'b0;
    wr(8'h08, 32'h3);
    @(negedge clk); cmpl_evt = 1'b1; addr = 8'h00; wdata = 32'h1; wr_en = 1'b1;
    @(negedge clk); cmpl_evt = 1'b0; wr_en = 1'b0;
    rd(8'h00, d); chk("R1 set beats clear", d, 32'h1);
    evt(1'b0, 1'b1);
    @(negedge clk); adapter_rst = 1'b1; cmpl_evt = 1'b1;
    @(negedge clk); adapter_rst = 1'b0; cmpl_evt = 1'b0;
    rd(8'h00, d); chk("R9 status cleared", d, 0);
    rd(8'h08, d); chk("R9 mask kept", d, 32'h3);
    chk("R9 level low", 32'(irq_level), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_legacy();
    t_message();
    t_retry();
    t_collide_and_areset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule